// File: doc/BRIEF.md
# Output Protection and Fault Supervisor

This block sits between the host-written control word of a twelve-channel driver and the power stages. It gates each requested channel with the fault state. Channels come in pairs: each pair has one low-side and one high-side switch. The block also keeps the sticky fault flags and builds the status word that the serial logic shifts back to the host. The analog side is not modelled: overcurrent, undervoltage, thermal prewarning, thermal shutdown and open-load comparators arrive as digital flags. A slow timebase tick paces the delay timers.

A short on one channel shuts only that channel, after a programmable delay. If the die is already warm, the short shuts the channel at once. A supply dip that lasts long enough turns everything off until the supply recovers. Thermal shutdown turns everything off and stays latched. Short and thermal faults need a host status-reset write before the channels return. Undervoltage needs no such write.

Top module: `output_fault_supervisor`

## Requirements
- R1: Control word layout, with N channels (default 12): bit 0 is status-reset, bits N..1 request channels 0..N-1, bit N+1 is open-load-detect-off (0 = detection on), bit N+2 is delay-select (1 = long), and bit N+3 is run. Channel k uses control bit k+1 and drives `drv_en[k]`. Even k is a low-side switch and odd k is a high-side switch. When no fault is present and the block is not in standby, `drv_en` equals the requested bits.
- R2: With delay-select 0, a channel whose overcurrent flag stays high while it is driven is switched off after SC_SHORT_TICKS ticks, and not before. Status bit N+1 (short flag) is then 1.
- R3: With delay-select 1, the same trip needs SC_LONG_TICKS ticks.
- R4: A channel's overcurrent timer restarts from zero whenever its overcurrent flag drops before expiry.
- R5: While the prewarning flag is high, a driven channel with overcurrent is switched off on the next clock, with no ticks, and the short flag is set.
- R6: A status reset is a `ctrl_load` pulse with bit 0 set. It clears the short flag and re-enables tripped channels.
- R7: Undervoltage lasting UV_SHORT_TICKS ticks (UV_LONG_TICKS with delay-select 1) switches all outputs off and sets status bit N+3 (supply fail). Outputs return as soon as undervoltage clears. The supply-fail bit stays set until a status reset.
- R8: Thermal shutdown switches all outputs off and forces the status word to all ones. The latch clears only on a status reset written while the shutdown flag is low.
- R9: Status bit 0 follows the prewarning flag live, without latching.
- R10: Status bit N+2 is 1 and all outputs are off when the run bit is 0 or `inhibit_n` is low.
- R11: Status bit k+1 shows `drv_en[k]`. When open-load detection is on and channel k is not requested, status bit k+1 shows `ol_flags[k]` instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timebase pulse for all delay timers |
| ctrl_word | input | N+4 | Committed control word |
| ctrl_load | input | 1 | One-cycle pulse when a new word is committed |
| oc_flags | input | N | Per-channel overcurrent flags |
| ol_flags | input | N | Per-channel open-load comparator results |
| uv_flag | input | 1 | Supply undervoltage flag |
| prewarn_flag | input | 1 | Thermal prewarning flag |
| tsd_flag | input | 1 | Thermal shutdown flag |
| inhibit_n | input | 1 | Hardware inhibit pin, low = standby |
| drv_en | output | N | Gated output enables in control-bit order |
| status_word | output | N+4 | Status word for readback |

## Verification
The bench counts ticks to the exact trip boundary for both delay settings. A timer that is off by one trips one tick early, or lets the channel survive one tick too long. It drops the overcurrent partway through a count to catch a timer that only pauses and so trips early. It writes a status reset while the thermal flag is still high, which a design that clears unconditionally would wrongly obey. It releases undervoltage without a reset to catch outputs left stuck off, or a supply-fail bit that clears itself. It also checks that open-load reporting on an off channel does not leak into a channel that is on.

// File: rtl/drv_supervisor_pkg.sv
// Package: shared field positions of the control and status words.
// Assumes the word is N channel bits plus four fixed bits.
package drv_supervisor_pkg;

    localparam int F_SRR = 0;   // status-reset request
    localparam int F_CH0 = 1;   // first channel request bit

    // Position of the open-load-detect-off bit for n channels.
    function automatic int pos_oloff(input int n);
        return n + 1;
    endfunction

    // Position of the long-delay select bit.
    function automatic int pos_dsel(input int n);
        return n + 2;
    endfunction

    // Position of the run bit.
    function automatic int pos_run(input int n);
        return n + 3;
    endfunction

    // Status word positions.
    localparam int S_PREWARN = 0;

    function automatic int pos_short(input int n);
        return n + 1;
    endfunction

    function automatic int pos_stby(input int n);
        return n + 2;
    endfunction

    function automatic int pos_psf(input int n);
        return n + 3;
    endfunction

endpackage

// File: rtl/fault_delay_timer.sv
// Module: fault_delay_timer
// Counts timebase ticks while a condition is held. It reports expiry once
// the count reaches the selected limit. Dropping the condition restarts it.
// Assumes tick is a single-cycle pulse.
module fault_delay_timer #(
    parameter int SHORT_TICKS = 3,
    parameter int LONG_TICKS  = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic long_sel,
    input  logic active,
    output logic expired
);
    localparam int MAXT = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int CW   = $clog2(MAXT + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    // Select the active limit.
    always_comb limit = long_sel ? CW'(LONG_TICKS) : CW'(SHORT_TICKS);

    // Advance on ticks while held; restart when released.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!active)
            cnt <= '0;
        else if (tick && (cnt < limit))
            cnt <= cnt + 1'b1;
    end

    // Expiry is only meaningful while the condition persists.
    always_comb expired = active && (cnt >= limit);

    p_count_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(MAXT));

    p_restart_on_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cnt == '0));

endmodule

// File: rtl/channel_short_guard.sv
// Module: channel_short_guard
// Per-channel short protection. It times overcurrent on a driven channel
// and latches the channel off on expiry, or at once under prewarning.
// The latch holds until a status reset.
// Assumes oc_i is only meaningful while the channel is driven.
module channel_short_guard #(
    parameter int SHORT_TICKS = 3,
    parameter int LONG_TICKS  = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic long_sel,
    input  logic pass_i,
    input  logic oc_i,
    input  logic prewarn_i,
    input  logic clear_i,
    output logic en_o,
    output logic tripped_o
);
    logic tripped;
    logic oc_active;
    logic timer_done;
    logic trip_now;

    // Enable survives only while no short latch is held.
    always_comb en_o = pass_i && !tripped;

    // Overcurrent counts only on a channel that is actually driven.
    always_comb oc_active = oc_i && en_o;

    fault_delay_timer #(
        .SHORT_TICKS (SHORT_TICKS),
        .LONG_TICKS  (LONG_TICKS)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .long_sel (long_sel),
        .active   (oc_active),
        .expired  (timer_done)
    );

    // Trip after the delay, or immediately when the die is warm.
    always_comb trip_now = oc_active && (prewarn_i || timer_done);

    // Short latch: a status reset wins over a new trip in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tripped <= 1'b0;
        else if (clear_i)
            tripped <= 1'b0;
        else if (trip_now)
            tripped <= 1'b1;
    end

    always_comb tripped_o = tripped;

    p_trip_needs_overcurrent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tripped) |-> $past(oc_i && pass_i));

    p_prewarn_immediate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_i && en_o && prewarn_i && !clear_i) |=> tripped);

    p_reset_rearms_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !tripped);

endmodule

// File: rtl/supply_thermal_monitor.sv
// Module: supply_thermal_monitor
// Times undervoltage and latches the supply-fail flag. Blocks outputs only
// while the expired undervoltage persists. Latches thermal shutdown until
// a status reset arrives with the thermal flag low.
// Assumes uv_i and tsd_i are already synchronous to clk.
module supply_thermal_monitor #(
    parameter int UV_SHORT_TICKS = 2,
    parameter int UV_LONG_TICKS  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic long_sel,
    input  logic uv_i,
    input  logic tsd_i,
    input  logic clear_i,
    output logic uv_block_o,
    output logic psf_o,
    output logic tsd_latch_o
);
    logic uv_done;
    logic psf;
    logic tsd_latch;

    fault_delay_timer #(
        .SHORT_TICKS (UV_SHORT_TICKS),
        .LONG_TICKS  (UV_LONG_TICKS)
    ) u_uv_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .long_sel (long_sel),
        .active   (uv_i),
        .expired  (uv_done)
    );

    // Outputs are blocked exactly while the expired condition holds.
    always_comb uv_block_o = uv_done;

    // Supply-fail flag: set wins, so a persisting fault keeps reporting.
    always_ff @(posedge clk) begin
        if (!rst_n)
            psf <= 1'b0;
        else if (uv_done)
            psf <= 1'b1;
        else if (clear_i)
            psf <= 1'b0;
    end

    // Thermal latch: cleared only after cooling plus a status reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tsd_latch <= 1'b0;
        else if (tsd_i)
            tsd_latch <= 1'b1;
        else if (clear_i)
            tsd_latch <= 1'b0;
    end

    always_comb psf_o       = psf;
    always_comb tsd_latch_o = tsd_latch;

    p_psf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (psf && !clear_i) |=> psf);

    p_uv_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !uv_i |-> !uv_block_o);

    p_tsd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tsd_latch && !(clear_i && !tsd_i)) |=> tsd_latch);

endmodule

// File: rtl/status_word_builder.sv
// Module: status_word_builder
// Combinational assembly of the readback word. Channel bits show drive
// state, or the open-load comparator for idle channels when detection is on.
// Thermal shutdown overrides every bit to one.
module status_word_builder
    import drv_supervisor_pkg::*;
#(
    parameter int N_CH = 12,
    localparam int W   = N_CH + 4
) (
    input  logic            prewarn_i,
    input  logic [N_CH-1:0] drv_i,
    input  logic [N_CH-1:0] req_i,
    input  logic            ol_on_i,
    input  logic [N_CH-1:0] ol_i,
    input  logic            short_i,
    input  logic            standby_i,
    input  logic            psf_i,
    input  logic            tsd_i,
    output logic [W-1:0]    status_o
);
    logic [N_CH-1:0] ch_bits;

    // Per-channel source select.
    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        always_comb ch_bits[g] = (ol_on_i && !req_i[g]) ? ol_i[g] : drv_i[g];
    end

    // Place every field, then apply the thermal override.
    always_comb begin
        status_o                       = '0;
        status_o[S_PREWARN]            = prewarn_i;
        status_o[N_CH:1]               = ch_bits;
        status_o[pos_short(N_CH)]      = short_i;
        status_o[pos_stby(N_CH)]       = standby_i;
        status_o[pos_psf(N_CH)]        = psf_i;
        if (tsd_i)
            status_o = '1;
    end

endmodule

// File: rtl/output_fault_supervisor.sv
// Module: output_fault_supervisor
// Top of the protection block. It decodes the committed control word,
// gates every channel with standby, undervoltage, thermal and per-channel
// short state, and publishes the status word. Assumes ctrl_word stays
// stable between ctrl_load pulses and that all flags are synchronous.
module output_fault_supervisor
    import drv_supervisor_pkg::*;
#(
    parameter int N_PAIRS        = 6,
    parameter int SC_SHORT_TICKS = 3,
    parameter int SC_LONG_TICKS  = 12,
    parameter int UV_SHORT_TICKS = 2,
    parameter int UV_LONG_TICKS  = 8,
    localparam int N_CH          = 2 * N_PAIRS,
    localparam int W             = N_CH + 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [W-1:0]    ctrl_word,
    input  logic            ctrl_load,
    input  logic [N_CH-1:0] oc_flags,
    input  logic [N_CH-1:0] ol_flags,
    input  logic            uv_flag,
    input  logic            prewarn_flag,
    input  logic            tsd_flag,
    input  logic            inhibit_n,
    output logic [N_CH-1:0] drv_en,
    output logic [W-1:0]    status_word
);
    logic [N_CH-1:0] req;
    logic [N_CH-1:0] tripped;
    logic            long_sel;
    logic            ol_on;
    logic            run;
    logic            status_clear;
    logic            standby;
    logic            uv_block;
    logic            psf;
    logic            tsd_latch;
    logic            global_ok;

    // Decode the control fields.
    always_comb begin
        req          = ctrl_word[N_CH:F_CH0];
        ol_on        = !ctrl_word[pos_oloff(N_CH)];
        long_sel     = ctrl_word[pos_dsel(N_CH)];
        run          = ctrl_word[pos_run(N_CH)];
        status_clear = ctrl_load && ctrl_word[F_SRR];
    end

    // Standby from either the software run bit or the hardware pin.
    always_comb standby = !run || !inhibit_n;

    supply_thermal_monitor #(
        .UV_SHORT_TICKS (UV_SHORT_TICKS),
        .UV_LONG_TICKS  (UV_LONG_TICKS)
    ) u_supply (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .long_sel    (long_sel),
        .uv_i        (uv_flag),
        .tsd_i       (tsd_flag),
        .clear_i     (status_clear),
        .uv_block_o  (uv_block),
        .psf_o       (psf),
        .tsd_latch_o (tsd_latch)
    );

    // Conditions shared by every channel.
    always_comb global_ok = !standby && !uv_block && !tsd_latch;

    for (genvar g = 0; g < N_CH; g++) begin : g_guard
        channel_short_guard #(
            .SHORT_TICKS (SC_SHORT_TICKS),
            .LONG_TICKS  (SC_LONG_TICKS)
        ) u_guard (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .long_sel  (long_sel),
            .pass_i    (req[g] && global_ok),
            .oc_i      (oc_flags[g]),
            .prewarn_i (prewarn_flag),
            .clear_i   (status_clear),
            .en_o      (drv_en[g]),
            .tripped_o (tripped[g])
        );
    end

    status_word_builder #(
        .N_CH (N_CH)
    ) u_status (
        .prewarn_i (prewarn_flag),
        .drv_i     (drv_en),
        .req_i     (req),
        .ol_on_i   (ol_on),
        .ol_i      (ol_flags),
        .short_i   (|tripped),
        .standby_i (standby),
        .psf_i     (psf),
        .tsd_i     (tsd_latch),
        .status_o  (status_word)
    );

    p_standby_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> (drv_en == '0));

    p_uv_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        uv_block |-> (drv_en == '0));

    p_tsd_all_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tsd_latch |-> ((&status_word) && (drv_en == '0)));

    p_prewarn_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tsd_latch |-> (status_word[S_PREWARN] == prewarn_flag));

    p_drive_subset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en & ~req) == '0);

endmodule

// File: tb/output_fault_supervisor_test.sv
module output_fault_supervisor_test;
    localparam int N  = 12;
    localparam int W  = 16;
    localparam int SCS = 3, SCL = 12, UVS = 2, UVL = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic [W-1:0]  ctrl_word = '0;
    logic          ctrl_load = 1'b0;
    logic [N-1:0]  oc_flags = '0;
    logic [N-1:0]  ol_flags = '0;
    logic          uv_flag = 1'b0;
    logic          prewarn_flag = 1'b0;
    logic          tsd_flag = 1'b0;
    logic          inhibit_n = 1'b1;
    logic [N-1:0]  drv_en;
    logic [W-1:0]  status_word;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    output_fault_supervisor uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl_word(ctrl_word),
        .ctrl_load(ctrl_load), .oc_flags(oc_flags), .ol_flags(ol_flags),
        .uv_flag(uv_flag), .prewarn_flag(prewarn_flag), .tsd_flag(tsd_flag),
        .inhibit_n(inhibit_n), .drv_en(drv_en), .status_word(status_word)
    );

    function automatic logic [W-1:0] mkw(bit run, bit lsel, bit oloff, logic [N-1:0] ch);
        return {run, lsel, oloff, ch, 1'b0};
    endfunction

    function automatic logic [W-1:0] st(bit psf, bit stby, bit sc, logic [N-1:0] ch, bit pw);
        return {psf, stby, sc, ch, pw};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
        settle();
    endtask

    task automatic commit(logic [W-1:0] w);
        @(negedge clk);
        ctrl_word = w;
        ctrl_load = 1'b1;
        @(negedge clk);
        ctrl_load = 1'b0;
        settle();
    endtask

    task automatic status_reset(logic [W-1:0] w);
        commit(w | 16'h0001);
        commit(w);
    endtask

    task automatic t_reset();
        ctrl_word = mkw(1, 0, 1, '0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle();
        chk("R1", "reset drive", drv_en, 0);
        chk("R1", "reset status", status_word, 0);
    endtask

    task automatic t_mapping();
        commit(mkw(1, 0, 1, 12'hA5C));
        chk("R1", "pattern A5C drive", drv_en, 12'hA5C);
        chk("R11", "pattern A5C status", status_word, st(0, 0, 0, 12'hA5C, 0));
        commit(mkw(1, 0, 1, 12'h3F0));
        chk("R1", "pattern 3F0 drive", drv_en, 12'h3F0);
    endtask

    task automatic t_short_delay();
        logic [W-1:0] w = mkw(1, 0, 1, 12'hFFF);
        commit(w);
        oc_flags[3] = 1'b1;
        ticks(SCS - 1);
        chk("R2", "before short delay", drv_en, 12'hFFF);
        ticks(1);
        chk("R2", "at short delay", drv_en, 12'hFF7);
        chk("R2", "short flag", status_word, st(0, 0, 1, 12'hFF7, 0));
        oc_flags[3] = 1'b0;
        settle();
        chk("R6", "tripped stays off", drv_en, 12'hFF7);
        status_reset(w);
        chk("R6", "re-enabled", drv_en, 12'hFFF);
        chk("R6", "short flag cleared", status_word, st(0, 0, 0, 12'hFFF, 0));
    endtask

    task automatic t_long_delay();
        logic [W-1:0] w = mkw(1, 1, 1, 12'hFFF);
        commit(w);
        oc_flags[0] = 1'b1;
        ticks(SCL - 1);
        chk("R3", "before long delay", drv_en, 12'hFFF);
        ticks(1);
        chk("R3", "at long delay", drv_en, 12'hFFE);
        oc_flags[0] = 1'b0;
        status_reset(w);
    endtask

    task automatic t_restart();
        logic [W-1:0] w = mkw(1, 0, 1, 12'hFFF);
        commit(w);
        oc_flags[5] = 1'b1;
        ticks(SCS - 1);
        oc_flags[5] = 1'b0;
        settle();
        ticks(1);
        oc_flags[5] = 1'b1;
        ticks(SCS - 1);
        chk("R4", "restarted count", drv_en, 12'hFFF);
        ticks(1);
        chk("R4", "trip after full delay", drv_en, 12'hFDF);
        oc_flags[5] = 1'b0;
        status_reset(w);
    endtask

    task automatic t_prewarn();
        logic [W-1:0] w = mkw(1, 0, 1, 12'hFFF);
        commit(w);
        prewarn_flag = 1'b1;
        settle();
        chk("R9", "prewarn bit set", status_word, st(0, 0, 0, 12'hFFF, 1));
        oc_flags[7] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R5", "immediate trip", drv_en, 12'hF7F);
        chk("R5", "short flag", status_word[13], 1);
        oc_flags[7] = 1'b0;
        prewarn_flag = 1'b0;
        settle();
        chk("R9", "prewarn bit follows", status_word[0], 0);
        status_reset(w);
        chk("R6", "after prewarn trip", drv_en, 12'hFFF);
    endtask

    task automatic t_uv();
        logic [W-1:0] w = mkw(1, 0, 1, 12'hFFF);
        commit(w);
        uv_flag = 1'b1;
        ticks(UVS - 1);
        chk("R7", "before uv delay", drv_en, 12'hFFF);
        ticks(1);
        chk("R7", "uv off", drv_en, 0);
        chk("R7", "psf set", status_word, st(1, 0, 0, 12'h000, 0));
        uv_flag = 1'b0;
        @(negedge clk);
        chk("R7", "uv recovery", drv_en, 12'hFFF);
        chk("R7", "psf sticky", status_word, st(1, 0, 0, 12'hFFF, 0));
        status_reset(w);
        chk("R7", "psf cleared", status_word, st(0, 0, 0, 12'hFFF, 0));
    endtask

    task automatic t_uv_long();
        logic [W-1:0] w = mkw(1, 1, 1, 12'h00F);
        commit(w);
        uv_flag = 1'b1;
        ticks(UVL - 1);
        chk("R7", "before long uv delay", drv_en, 12'h00F);
        ticks(1);
        chk("R7", "long uv off", drv_en, 0);
        uv_flag = 1'b0;
        settle();
        status_reset(w);
    endtask

    task automatic t_tsd();
        logic [W-1:0] w = mkw(1, 0, 1, 12'hFFF);
        commit(w);
        tsd_flag = 1'b1;
        settle();
        chk("R8", "tsd drive", drv_en, 0);
        chk("R8", "tsd status ones", status_word, 16'hFFFF);
        status_reset(w);
        chk("R8", "reset while hot ignored", status_word, 16'hFFFF);
        tsd_flag = 1'b0;
        settle();
        chk("R8", "cool but not reset", drv_en, 0);
        status_reset(w);
        chk("R8", "recovered drive", drv_en, 12'hFFF);
        chk("R8", "recovered status", status_word, st(0, 0, 0, 12'hFFF, 0));
    endtask

    task automatic t_standby();
        commit(mkw(1, 0, 1, 12'hFFF));
        inhibit_n = 1'b0;
        settle();
        chk("R10", "pin standby drive", drv_en, 0);
        chk("R10", "pin standby status", status_word, st(0, 1, 0, 12'h000, 0));
        inhibit_n = 1'b1;
        commit(mkw(0, 0, 1, 12'hFFF));
        chk("R10", "soft standby drive", drv_en, 0);
        chk("R10", "soft standby status", status_word, st(0, 1, 0, 12'h000, 0));
    endtask

    task automatic t_openload();
        ol_flags = 12'h0A3;
        commit(mkw(1, 0, 0, 12'h00F));
        chk("R11", "open-load view", status_word, st(0, 0, 0, 12'h0AF, 0));
        chk("R11", "open-load drive", drv_en, 12'h00F);
        commit(mkw(1, 0, 1, 12'h00F));
        chk("R11", "detection off view", status_word, st(0, 0, 0, 12'h00F, 0));
        ol_flags = '0;
    endtask

    initial begin
        t_reset();
        t_mapping();
        t_short_delay();
        t_long_delay();
        t_restart();
        t_prewarn();
        t_uv();
        t_uv_long();
        t_tsd();
        t_standby();
        t_openload();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #2ms;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule